// File: doc/BRIEF.md
# SMBus Stretch and Lock-up Guard

This block sits beside the target-side protocol engine of an SMBus/PMBus interface and watches the SCL and SDA wires. The target never makes clock edges and never starts a transfer. The only thing it may do on its own is hold SCL low. The guard decides when that hold is allowed. The protocol engine supplies two bit-phase markers: a one-cycle pulse when the ninth (acknowledge) bit of a byte has completed, and a level that is high during the START phase. The local logic supplies a busy level. When busy is seen together with one of these markers, the guard asserts an open-drain hold on SCL. It keeps the hold until busy falls or until the stretch has lasted the maximum allowed time, whichever comes first.

Separately, the guard times how long each wire stays low without a break. If either wire is low for the lock-up limit, it emits a single-cycle abort pulse and enters a released state. In that state it asks the target to let go of both wires, and it ignores busy. It leaves this state on a STOP condition or after both wires have been high for an idle period. All limits are counted in milliseconds, using a parameter that gives the number of system clocks per millisecond. For that reason the guard does not depend on the SCL rate: 100 kHz (the usual default), 400 kHz and clocks as slow as 10 kHz all have low phases far below the limits. Two sticky flags record a stretch timeout and a lock-up timeout, and a clear input resets both.

Top module: `smb_stretch_guard`

## Requirements
- R1: After reset, scl_hold_o, abort_o, bus_release_o, stretch_to_o and lockup_to_o are 0 and ready_o is 1.
- R2: A hold starts (scl_hold_o goes to 1 after the next clock edge) only when busy_i is 1 in a cycle where ack_done_i or start_phase_i is 1. A busy_i that arrives outside such a cycle leaves scl_hold_o at 0.
- R3: While a hold is active and busy_i stays 1, scl_hold_o stays 1. It returns to 0 after the first clock edge that sees busy_i at 0.
- R4: A single hold lasts at most STRETCH_MS*CLKS_PER_MS+1 cycles. When it is cut at the cap, stretch_to_o is set. No new hold can start until busy_i has dropped, even if a marker arrives.
- R5: When the synchronized SCL or SDA (each sampled through two flops) stays 0 for LOCKUP_MS*CLKS_PER_MS cycles, abort_o is 1 for exactly one cycle and lockup_to_o is set. The pulse appears at most 3 cycles after that point.
- R6: A low phase shorter than the lock-up limit causes no abort. The low-time count restarts each time the wire is seen high, so an ordinary clock train never trips it.
- R7: After an abort, bus_release_o is 1, ready_o is 0 and scl_hold_o is 0, and busy_i together with a marker is ignored. The guard returns to ready on a STOP (synchronized SDA rising while synchronized SCL is 1), or after both wires have been 1 for IDLE_MS*CLKS_PER_MS cycles.
- R8: stretch_to_o and lockup_to_o stay set until clear_i is 1. clear_i resets both, but a flag being set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL wire level (asynchronous) |
| sda_i | input | 1 | SDA wire level (asynchronous) |
| busy_i | input | 1 | Local logic requests a clock stretch |
| ack_done_i | input | 1 | Pulse: ninth bit of a byte completed |
| start_phase_i | input | 1 | Level: bus is in the START phase |
| clear_i | input | 1 | Clears both timeout flags |
| scl_hold_o | output | 1 | Open-drain request to pull SCL low |
| bus_release_o | output | 1 | Target must release SCL and SDA |
| abort_o | output | 1 | One-cycle transaction abort pulse |
| ready_o | output | 1 | Guard is not in the released state |
| stretch_to_o | output | 1 | Sticky: a stretch reached the cap |
| lockup_to_o | output | 1 | Sticky: a wire stayed low too long |

## Verification
The bench builds the guard with CLKS_PER_MS=10, STRETCH_MS=25, LOCKUP_MS=35 and IDLE_MS=2. With these values the stretch cap is about 250 cycles, the lock-up limit about 350 cycles and the idle exit about 20 cycles. Every millisecond limit can therefore be reached and also approached from just below within a short run. The small idle window sits well clear of the few-cycle STOP path, so the bench can tell the two exits from the released state apart. A random busy/marker phase, with bursts kept far shorter than the cap, checks the start and release rules cycle by cycle against a bench-side model.

// File: rtl/smb_guard_pkg.sv
package smb_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_ABORT = 2'd3
  } guard_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  // idle bus is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/smb_ms_timer.sv
module smb_ms_timer #(
  parameter int CLKS_PER_MS = 100000,
  parameter int LIMIT_MS    = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int SW = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MW = $clog2(LIMIT_MS + 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(CLKS_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(LIMIT_MS);

  logic [SW-1:0] sub_q;
  logic [MW-1:0] ms_q;
  logic          done;

  assign done = (ms_q == MS_LAST);

  // private prescaler: restarts with run_i so the window is cycle-exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      ms_q  <= '0;
    end else if (!run_i) begin
      sub_q <= '0;
      ms_q  <= '0;
    end else if (!done) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign expired_o = done;

  a_r4_expiry_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(run_i));
  a_r6_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !expired_o);
endmodule

// File: rtl/smb_guard_ctrl.sv
module smb_guard_ctrl
  import smb_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic busy_i,
  input  logic ack_done_i,
  input  logic start_phase_i,
  input  logic clear_i,
  input  logic stretch_exp_i,
  input  logic lock_exp_i,
  input  logic idle_exp_i,
  output logic scl_hold_o,
  output logic bus_release_o,
  output logic abort_o,
  output logic ready_o,
  output logic stretch_to_o,
  output logic lockup_to_o
);
  guard_state_e state_q, state_d;
  logic lock_q, sda_q, abort_q, sto_q, lto_q;
  logic lock_rise, stop_seen, legal_start, cap_hit, abort_set;

  assign lock_rise   = lock_exp_i & ~lock_q;
  assign stop_seen   = sda_s_i & ~sda_q & scl_s_i;
  assign legal_start = busy_i & (ack_done_i | start_phase_i);
  assign cap_hit     = (state_q == ST_HOLD) & busy_i & stretch_exp_i & ~lock_rise;
  assign abort_set   = (state_q != ST_ABORT) & lock_rise;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (lock_rise)        state_d = ST_ABORT;
        else if (legal_start) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (lock_rise)          state_d = ST_ABORT;
        else if (!busy_i)       state_d = ST_IDLE;
        else if (stretch_exp_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (lock_rise)    state_d = ST_ABORT;
        else if (!busy_i) state_d = ST_IDLE;
      end
      ST_ABORT: begin
        if (stop_seen || idle_exp_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
      sda_q   <= 1'b1;
      abort_q <= 1'b0;
      sto_q   <= 1'b0;
      lto_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_exp_i;
      sda_q   <= sda_s_i;
      abort_q <= abort_set;
      // set beats clear
      if (cap_hit)      sto_q <= 1'b1;
      else if (clear_i) sto_q <= 1'b0;
      if (abort_set)    lto_q <= 1'b1;
      else if (clear_i) lto_q <= 1'b0;
    end
  end

  assign scl_hold_o    = (state_q == ST_HOLD);
  assign bus_release_o = (state_q == ST_ABORT);
  assign ready_o       = (state_q != ST_ABORT);
  assign abort_o       = abort_q;
  assign stretch_to_o  = sto_q;
  assign lockup_to_o   = lto_q;

  a_r2_legal_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> $past(busy_i && (ack_done_i || start_phase_i)));
  a_r3_release_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !scl_hold_o);
  a_r4_no_restart_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) && busy_i |=> !scl_hold_o);
  a_r5_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  a_r7_released_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_release_o |-> !scl_hold_o && !ready_o);
  a_r8_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stretch_to_o || lockup_to_o) && !clear_i |=> (stretch_to_o || lockup_to_o));
endmodule

// File: rtl/smb_stretch_guard.sv
module smb_stretch_guard #(
  parameter int CLKS_PER_MS = 100000,
  parameter int STRETCH_MS  = 25,
  parameter int LOCKUP_MS   = 35,
  parameter int IDLE_MS     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic busy_i,
  input  logic ack_done_i,
  input  logic start_phase_i,
  input  logic clear_i,
  output logic scl_hold_o,
  output logic bus_release_o,
  output logic abort_o,
  output logic ready_o,
  output logic stretch_to_o,
  output logic lockup_to_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] lock_exp;
  logic stretch_exp, idle_exp;

  smb_line_sync #(.WIDTH(NLINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (line_s)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_lock
    smb_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .LIMIT_MS(LOCKUP_MS)) u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (~line_s[g]),
      .expired_o(lock_exp[g])
    );
  end

  smb_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .LIMIT_MS(STRETCH_MS)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (scl_hold_o),
    .expired_o(stretch_exp)
  );

  smb_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .LIMIT_MS(IDLE_MS)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (bus_release_o & (&line_s)),
    .expired_o(idle_exp)
  );

  smb_guard_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_s_i      (line_s[0]),
    .sda_s_i      (line_s[1]),
    .busy_i       (busy_i),
    .ack_done_i   (ack_done_i),
    .start_phase_i(start_phase_i),
    .clear_i      (clear_i),
    .stretch_exp_i(stretch_exp),
    .lock_exp_i   (|lock_exp),
    .idle_exp_i   (idle_exp),
    .scl_hold_o   (scl_hold_o),
    .bus_release_o(bus_release_o),
    .abort_o      (abort_o),
    .ready_o      (ready_o),
    .stretch_to_o (stretch_to_o),
    .lockup_to_o  (lockup_to_o)
  );

  a_r1_reset_ready: assert property (@(posedge clk_i)
    !rst_ni |=> ready_o && !abort_o && !scl_hold_o);
endmodule

// File: tb/test_smb_stretch_guard.sv
module test_smb_stretch_guard;
  localparam int CPM   = 10;
  localparam int ST_MS = 25;
  localparam int LK_MS = 35;
  localparam int ID_MS = 2;
  localparam int STRETCH_CYC = ST_MS * CPM;
  localparam int LOCK_CYC    = LK_MS * CPM;
  localparam int IDLE_CYC    = ID_MS * CPM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0, ack = 1'b0, stph = 1'b0, clr = 1'b0;
  logic hold, rel, abrt, rdy, sto, lto;
  logic scl_line;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign scl_line = m_scl & ~hold;

  smb_stretch_guard #(.CLKS_PER_MS(CPM), .STRETCH_MS(ST_MS), .LOCKUP_MS(LK_MS),
                      .IDLE_MS(ID_MS)) i_smb_stretch_guard (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(m_sda),
    .busy_i(busy), .ack_done_i(ack), .start_phase_i(stph), .clear_i(clr),
    .scl_hold_o(hold), .bus_release_o(rel), .abort_o(abrt), .ready_o(rdy),
    .stretch_to_o(sto), .lockup_to_o(lto)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit in_win(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic bit model_hold(input bit h, input bit b, input bit a, input bit s);
    return b & (h | a | s);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cnt;
    bit seen_hold, seen_abort, exp_h;
    void'($urandom(32'd4711));
    step(3);
    // R1 reset state
    chk(hold == 0 && abrt == 0 && rel == 0, "R1 outputs idle", {hold, abrt, rel}, 0);
    chk(sto == 0 && lto == 0 && rdy == 1, "R1 flags/ready", {sto, lto, rdy}, 1);
    rst_n = 1'b1;
    step(2);
    chk(rdy == 1 && hold == 0, "R1 after release", {rdy, hold}, 2);

    // R2 busy without a marker is ignored
    busy = 1'b1;
    seen_hold = 0;
    for (int i = 0; i < 20; i++) begin step(); if (hold) seen_hold = 1; end
    chk(!seen_hold, "R2 busy outside legal slot", seen_hold, 0);

    // R2/R3 stretch after ack
    ack = 1'b1; step(); ack = 1'b0;
    chk(hold == 1, "R2 hold after ack slot", hold, 1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); if (hold) cnt++; end
    chk(cnt == 30, "R3 hold kept while busy", cnt, 30);
    busy = 1'b0; step();
    chk(hold == 0, "R3 release after busy drop", hold, 0);
    step(5);

    // R2 start phase path
    stph = 1'b1; busy = 1'b1; step(); stph = 1'b0;
    chk(hold == 1, "R2 hold in start phase", hold, 1);
    busy = 1'b0; step();
    chk(hold == 0, "R3 release after start stretch", hold, 0);
    step(5);

    // R4 cap
    busy = 1'b1; ack = 1'b1; step(); ack = 1'b0;
    cnt = 1;
    for (int i = 0; i < 400; i++) begin step(); if (hold) cnt++; end
    chk(in_win(cnt, STRETCH_CYC, STRETCH_CYC + 1), "R4 stretch length capped", cnt, STRETCH_CYC + 1);
    chk(sto == 1, "R4 stretch timeout flag", sto, 1);
    chk(lto == 0 && rdy == 1, "R6 own stretch no lockup", lto, 0);
    ack = 1'b1; step(); ack = 1'b0; step();
    chk(hold == 0, "R4 no restart until busy drops", hold, 0);
    busy = 1'b0; step(10);
    chk(sto == 1, "R8 flag sticky", sto, 1);
    clr = 1'b1; step(); clr = 1'b0;
    chk(sto == 0, "R8 clear resets stretch flag", sto, 0);
    busy = 1'b1; ack = 1'b1; step(); ack = 1'b0;
    chk(hold == 1, "R4 new stretch after busy dropped", hold, 1);
    busy = 1'b0; step(5);

    // R6 low phase just under the limit, then clock train
    m_scl = 1'b0;
    seen_abort = 0;
    for (int i = 0; i < LOCK_CYC - 10; i++) begin step(); if (abrt) seen_abort = 1; end
    m_scl = 1'b1;
    for (int i = 0; i < 10; i++) begin step(); if (abrt) seen_abort = 1; end
    for (int i = 0; i < 200; i++) begin
      m_scl = (i % 4) < 2; step(); if (abrt) seen_abort = 1;
    end
    m_scl = 1'b1; step(5);
    chk(!seen_abort && rdy, "R6 sub-limit lows no abort", seen_abort, 0);

    // R5 SCL stuck low
    m_scl = 1'b0; cnt = 0;
    while (!abrt && cnt < LOCK_CYC + 50) begin step(); cnt++; end
    chk(in_win(cnt, LOCK_CYC, LOCK_CYC + 3), "R5 abort timing on SCL", cnt, LOCK_CYC + 3);
    step();
    chk(abrt == 0, "R5 abort is one cycle", abrt, 0);
    chk(lto == 1, "R5 lockup flag", lto, 1);
    chk(rel == 1 && rdy == 0, "R7 released state", {rel, rdy}, 2);
    busy = 1'b1; ack = 1'b1; step(); ack = 1'b0; step();
    chk(hold == 0, "R7 busy ignored while released", hold, 0);
    busy = 1'b0;
    m_scl = 1'b1; step(10);
    chk(rdy == 0, "R7 no early exit without STOP", rdy, 0);
    step(IDLE_CYC + 5);
    chk(rdy == 1 && rel == 0, "R7 idle exit", rdy, 1);
    clr = 1'b1; step(); clr = 1'b0;
    chk(lto == 0, "R8 clear resets lockup flag", lto, 0);

    // R5 SDA stuck low, STOP exit
    m_sda = 1'b0; cnt = 0;
    while (!abrt && cnt < LOCK_CYC + 50) begin step(); cnt++; end
    chk(in_win(cnt, LOCK_CYC, LOCK_CYC + 3), "R5 abort timing on SDA", cnt, LOCK_CYC + 3);
    step(3);
    m_sda = 1'b1; step(5);
    chk(rdy == 1, "R7 STOP exit", rdy, 1);
    step(5);

    // R2/R3 random busy and markers
    exp_h = hold;
    for (int i = 0; i < 3000; i++) begin
      if (i > 0) chk(hold == exp_h, "R2 R3 random hold", hold, exp_h);
      if (($urandom % 16) == 0) busy = ~busy;
      ack  = (($urandom % 6) == 0);
      stph = (($urandom % 10) == 0);
      exp_h = model_hold(exp_h, busy, ack, stph);
      step();
    end
    busy = 1'b0; ack = 1'b0; stph = 1'b0;
    step(3);
    finished = 1'b1;
    summary();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end
endmodule